// File: doc/BRIEF.md
# User-Level Profiling Countdown Timer

This block lets unprivileged code arm a cycle-accurate profiling interrupt and take it without any trip through the kernel. Software programs a handler entry address, a stack skip distance and a cycle count through a small register port. Once a nonzero count is loaded the timer counts down by one every clock. When it runs out, the block asks the fetch unit to redirect to the handler.

The redirect request carries three values. The first is the handler entry address. The second is the instruction pointer of the interrupted code, which the handler saves as its resume address. The third is a new stack pointer, equal to the live stack pointer minus the programmed skip, so the handler's frame lands below the ABI red zone. The request is held, with its payload frozen, until the fetch unit acknowledges it. The timer disarms itself on expiry and stays idle until software loads a new count.

Top module: `upt_timer`

## Requirements
- R1: After reset the count, handler and skip registers all read zero, the timer is disarmed and `redir_valid` is low.
- R2: Register select 0 is the count, which holds the low CW bits of the write data. Select 1 is the handler address and select 2 is the stack skip. Select 3 reads zero and ignores writes. Reads are combinational and show current values.
- R3: Writing a nonzero count arms the timer. While armed and with no request pending, the count drops by exactly one per clock.
- R4: After a count N (N ≥ 1) is written, `redir_valid` first reads high N clock edges after the write edge.
- R5: On the expiry edge the request latches three values: `redir_target` takes the handler register, `redir_resume_pc` takes `cur_pc`, and `redir_sp` takes `cur_sp` minus the skip register, modulo 2^XLEN. All three are taken from the cycle in which the count reads 1.
- R6: After expiry the count reads zero and stays zero until software writes a new nonzero count.
- R7: A raised request stays high with an unchanged payload until `redir_ack` is seen. It clears on that edge. An acknowledge with no request pending has no effect.
- R8: While a request is pending the countdown is frozen, so no second expiry can occur. A count written during that time is held, and it starts decrementing on the first edge after the acknowledge.
- R9: Writing a count of zero disarms the timer and cancels any countdown in progress. No request follows.
- R10: A count write in the same cycle as an expiry wins: the new value is loaded and no request is raised from the old count.
- R11: Changing the handler or skip register while a request is pending does not alter the pending payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for read and write |
| reg_wdata | input | XLEN | Write data |
| reg_rdata | output | XLEN | Read data for the selected register |
| cur_pc | input | XLEN | Instruction pointer of the running code |
| cur_sp | input | XLEN | Stack pointer of the running code |
| redir_valid | output | 1 | Redirect request to the fetch unit |
| redir_ack | input | 1 | Fetch unit accepts the redirect |
| redir_target | output | XLEN | Handler entry address |
| redir_resume_pc | output | XLEN | Interrupted instruction pointer to save |
| redir_sp | output | XLEN | Stack pointer adjusted past the red zone |

## Verification
The bench drives a different random instruction and stack pointer on every cycle of a countdown. This makes a capture taken one cycle early or late distinguishable from a correct one. Counts are tried at the minimum of one and at random lengths up to twenty, which separates an off-by-one expiry from a correct one. Directed cases place a count write exactly on the expiry cycle, a zero write mid-countdown, and a reload and register rewrites while a request waits. These separate load priority, cancellation, the freeze while pending and payload latching from a design that merely counts and fires. Acknowledge delays of zero to three cycles, plus a stray acknowledge during a countdown, show that the request holds and releases only on a real acknowledge.

// File: rtl/upt_pkg.sv
package upt_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT   = 2'd0,
        SEL_HANDLER = 2'd1,
        SEL_SKIP    = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/upt_cfg_regs.sv
module upt_cfg_regs #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [1:0]      sel,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] handler,
    output logic [XLEN-1:0] skip
);
    import upt_pkg::*;

    typedef struct packed {
        logic [XLEN-1:0] handler;
        logic [XLEN-1:0] skip;
    } cfg_t;

    cfg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && sel == SEL_HANDLER) st_d.handler = wdata;
        if (we && sel == SEL_SKIP)    st_d.skip    = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign handler = st_q.handler;
    assign skip    = st_q.skip;

endmodule

// File: rtl/upt_countdown.sv
module upt_countdown #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          hold,
    output logic [CW-1:0] count,
    output logic          armed,
    output logic          fire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    typedef struct packed {
        logic [CW-1:0] count;
        logic          armed;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (load) begin
            st_d.count = load_val;
            st_d.armed = (load_val != '0);
        end else if (st_q.armed && !hold) begin
            st_d.count = st_q.count - ONE;
            if (st_q.count == ONE) begin
                st_d.armed = 1'b0;
                fire       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;
    assign armed = st_q.armed;

    // R3: one step per clock while running
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !hold && !load && count > ONE) |=> (armed && count == $past(count) - ONE));

    // R9: a zero load leaves the timer idle
    a_r9_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (!armed && count == '0));

    // R6: an idle timer always shows zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> count == '0);

    // R8: frozen while a request waits
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !load) |=> $stable(count));

endmodule

// File: rtl/upt_redirect.sv
module upt_redirect #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic [XLEN-1:0] handler,
    input  logic [XLEN-1:0] skip,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_sp,
    input  logic            ack,
    output logic            valid,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] resume,
    output logic [XLEN-1:0] sp_out
);
    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] resume;
        logic [XLEN-1:0] sp;
    } req_t;

    req_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && ack) st_d.valid = 1'b0;
        if (fire) begin
            st_d.valid  = 1'b1;
            st_d.target = handler;
            st_d.resume = cur_pc;
            st_d.sp     = cur_sp - skip;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid  = st_q.valid;
    assign target = st_q.target;
    assign resume = st_q.resume;
    assign sp_out = st_q.sp;

    // R7: request and payload hold until acknowledged
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ack) |=> (valid && $stable(target) && $stable(resume) && $stable(sp_out)));

    // R7: acknowledge releases the request
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ack && !fire) |=> !valid);

    // R5: payload taken from the expiry cycle
    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (valid && target == $past(handler) && resume == $past(cur_pc)
                  && sp_out == $past(cur_sp) - $past(skip)));

endmodule

// File: rtl/upt_timer.sv
module upt_timer #(
    parameter int XLEN = 32,
    parameter int CW   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [XLEN-1:0] reg_wdata,
    output logic [XLEN-1:0] reg_rdata,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_sp,
    output logic            redir_valid,
    input  logic            redir_ack,
    output logic [XLEN-1:0] redir_target,
    output logic [XLEN-1:0] redir_resume_pc,
    output logic [XLEN-1:0] redir_sp
);
    import upt_pkg::*;

    logic [XLEN-1:0] handler;
    logic [XLEN-1:0] skip;
    logic [CW-1:0]   count;
    logic            armed;
    logic            fire;
    logic            load;

    assign load = reg_we && (reg_addr == SEL_COUNT);

    upt_cfg_regs #(.XLEN(XLEN)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_we),
        .sel     (reg_addr),
        .wdata   (reg_wdata),
        .handler (handler),
        .skip    (skip)
    );

    upt_countdown #(.CW(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (reg_wdata[CW-1:0]),
        .hold     (redir_valid),
        .count    (count),
        .armed    (armed),
        .fire     (fire)
    );

    upt_redirect #(.XLEN(XLEN)) u_redir (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .handler (handler),
        .skip    (skip),
        .cur_pc  (cur_pc),
        .cur_sp  (cur_sp),
        .ack     (redir_ack),
        .valid   (redir_valid),
        .target  (redir_target),
        .resume  (redir_resume_pc),
        .sp_out  (redir_sp)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            SEL_COUNT:   reg_rdata[CW-1:0] = count;
            SEL_HANDLER: reg_rdata = handler;
            SEL_SKIP:    reg_rdata = skip;
            default:     reg_rdata = '0;
        endcase
    end

    // R8: no second expiry while a request is outstanding
    a_r8_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> !redir_valid);

    // R6: an expiry leaves the timer disarmed
    a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !load) |=> !armed);

endmodule

// File: tb/sim_upt_timer.sv
module sim_upt_timer;
    localparam int CLK_PERIOD = 10;
    localparam int XLEN = 32;
    localparam int CW   = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            reg_we;
    logic [1:0]      reg_addr;
    logic [XLEN-1:0] reg_wdata;
    logic [XLEN-1:0] reg_rdata;
    logic [XLEN-1:0] cur_pc;
    logic [XLEN-1:0] cur_sp;
    logic            redir_valid;
    logic            redir_ack;
    logic [XLEN-1:0] redir_target;
    logic [XLEN-1:0] redir_resume_pc;
    logic [XLEN-1:0] redir_sp;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [XLEN-1:0] handler_m = '0;
    logic [XLEN-1:0] skip_m    = '0;
    logic [XLEN-1:0] last_pc   = '0;
    logic [XLEN-1:0] last_sp   = '0;

    upt_timer #(.XLEN(XLEN), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cur_pc(cur_pc),
        .cur_sp(cur_sp), .redir_valid(redir_valid), .redir_ack(redir_ack),
        .redir_target(redir_target), .redir_resume_pc(redir_resume_pc),
        .redir_sp(redir_sp)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [XLEN-1:0] exp_sp(input logic [XLEN-1:0] sp,
                                               input logic [XLEN-1:0] sk);
        return sp - sk;
    endfunction

    task automatic check(input string req, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic next();
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, output logic [XLEN-1:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [1:0] a, input logic [XLEN-1:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        next();
        reg_we = 1'b0;
        if (a == 2'd1) handler_m = d;
        if (a == 2'd2) skip_m = d;
    endtask

    // count reads n now; walk it down with fresh pc/sp each cycle
    task automatic countdown(input int n, input string req);
        logic [XLEN-1:0] v;
        for (int i = 0; i < n; i++) begin
            rd(2'd0, v);
            check({req, " count R3"}, v, XLEN'(n - i));
            check({req, " no early request R4"}, XLEN'(redir_valid), '0);
            cur_pc = $urandom; cur_sp = $urandom;
            last_pc = cur_pc; last_sp = cur_sp;
            next();
        end
        check({req, " request raised R4"}, XLEN'(redir_valid), XLEN'(1));
        check({req, " target R5"}, redir_target, handler_m);
        check({req, " resume pc R5"}, redir_resume_pc, last_pc);
        check({req, " stack R5"}, redir_sp, exp_sp(last_sp, skip_m));
        rd(2'd0, v);
        check({req, " count zero after expiry R6"}, v, '0);
    endtask

    task automatic ack_req(input string req);
        redir_ack = 1'b1;
        next();
        redir_ack = 1'b0;
        check({req, " released by ack R7"}, XLEN'(redir_valid), '0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] v;
        logic [XLEN-1:0] t0, r0, s0;
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        cur_pc = '0; cur_sp = '0; redir_ack = 1'b0;
        repeat (3) next();
        rst_n = 1'b1;
        next();

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            check("R1 reset register", v, '0);
        end
        check("R1 reset request", XLEN'(redir_valid), '0);

        // R2 register map
        wr(2'd1, 32'h0040_1000);
        wr(2'd2, 32'h0000_0080);
        wr(2'd3, 32'hDEAD_BEEF);
        rd(2'd1, v); check("R2 handler readback", v, 32'h0040_1000);
        rd(2'd2, v); check("R2 skip readback", v, 32'h0000_0080);
        rd(2'd3, v); check("R2 unused select reads zero", v, '0);
        rd(2'd0, v); check("R2 unused write leaves count", v, '0);

        // R2 truncation, R3..R6 with the minimal count first
        wr(2'd0, 32'h0000_0001);
        countdown(1, "min");
        ack_req("min");
        wr(2'd0, 32'hABCD_0003);
        countdown(3, "trunc R2");

        // R7 hold while unacknowledged, R11 rewrite while pending
        t0 = redir_target; r0 = redir_resume_pc; s0 = redir_sp;
        wr(2'd1, 32'h0080_2000);
        wr(2'd2, 32'h0000_0100);
        check("R7 still pending", XLEN'(redir_valid), XLEN'(1));
        check("R11 target kept", redir_target, t0);
        check("R11 resume kept", redir_resume_pc, r0);
        check("R11 stack kept", redir_sp, s0);

        // R8 reload while pending stays frozen
        wr(2'd0, 32'd3);
        next();
        rd(2'd0, v); check("R8 frozen while pending", v, 32'd3);
        ack_req("R8");
        rd(2'd0, v); check("R8 held through ack edge", v, 32'd3);
        countdown(3, "R8 resume");
        ack_req("R8 second");

        // R7 stray ack has no effect
        wr(2'd0, 32'd4);
        redir_ack = 1'b1;
        next();
        redir_ack = 1'b0;
        check("R7 stray ack no request", XLEN'(redir_valid), '0);
        countdown(3, "R7 stray");
        ack_req("R7 stray");

        // R9 zero write cancels
        wr(2'd0, 32'd5);
        next();
        wr(2'd0, 32'd0);
        rd(2'd0, v); check("R9 count cleared", v, '0);
        for (int i = 0; i < 8; i++) begin
            next();
            check("R9 no request after cancel", XLEN'(redir_valid), '0);
        end

        // R10 write on expiry cycle wins
        wr(2'd0, 32'd3);
        next(); next();
        rd(2'd0, v); check("R10 at last cycle", v, 32'd1);
        wr(2'd0, 32'd7);
        check("R10 no request from old count", XLEN'(redir_valid), '0);
        countdown(7, "R10 reload");
        ack_req("R10");

        // R6 stays idle after expiry
        for (int i = 0; i < 5; i++) next();
        rd(2'd0, v); check("R6 idle stays zero", v, '0);
        check("R6 no new request", XLEN'(redir_valid), '0);

        // random runs
        for (int it = 0; it < 20; it++) begin
            int n, dly;
            wr(2'd1, $urandom);
            wr(2'd2, $urandom % 1024);
            n = 1 + int'($urandom % 20);
            wr(2'd0, XLEN'(n));
            countdown(n, "rand");
            t0 = redir_target; r0 = redir_resume_pc; s0 = redir_sp;
            dly = int'($urandom % 4);
            for (int d = 0; d < dly; d++) begin
                cur_pc = $urandom; cur_sp = $urandom;
                next();
                check("rand hold R7", XLEN'(redir_valid), XLEN'(1));
                check("rand payload R7", redir_resume_pc ^ redir_sp ^ redir_target, r0 ^ s0 ^ t0);
            end
            ack_req("rand");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule